// File: doc/BRIEF.md
# Memory Access Fault Checker

This block screens every memory access request before it is allowed on to permission checking. It decides whether the access must be aborted for one of three reasons, and it reports which reason applied. An alignment problem is found from the request alone. Translation and domain problems are found later, from the level-one descriptor that the table lookup returns. When an abort happens, the block gives a one-cycle abort pulse and a fault-type code, tells whether the access was section- or page-mapped, and keeps the faulting address in a register.

Alignment is screened first, whether or not address translation is switched on. A misaligned access is aborted at once and never waits for a descriptor. With translation switched off, an aligned access is let through at once. With translation switched on, the checker waits for the descriptor. That descriptor is then tested in a fixed order: first whether it is valid, then the access code of the domain it selects. If it passes both, the checker signals that the access may proceed to permission checking.

Top module: `acc_fault_check`

## Requirements
- R1: After reset, `req_ready` is 1 and `abort`, `proceed` and `fault_code` are 0.
- R2: Alignment checking is enabled when `align_en`=1. With it enabled, a data word access (`req_size`=10 or 11) whose `req_addr[1:0]` is not 00 is aborted. The outputs appear one cycle after the request is accepted: `fault_code`=001 and `fault_addr` holds the request address.
- R3: With alignment checking enabled, a halfword data access (`req_size`=01) is aborted with code 001 if `req_addr[0]`=1. A halfword access with `req_addr[1:0]`=10 is not aborted.
- R4: These accesses never get an alignment fault: instruction fetches (`req_ifetch`=1), byte accesses (`req_size`=00), and any access while `align_en`=0.
- R5: Alignment faults are raised whatever the value of `mmu_en`. A misaligned request leaves `req_ready` at 1, and a descriptor strobe that follows it is ignored.
- R6: If `mmu_en`=0 and the access is aligned, `proceed` pulses one cycle after the request is accepted, with no descriptor wait and no abort.
- R7: If `mmu_en`=1, the checker waits for `l1d_valid`. A descriptor whose bits [1:0] are 00 gives an abort one cycle later. The code is 010 if the latched `req_page` was 0 (section) and 011 if it was 1 (page), and `fault_page` equals the latched `req_page`.
- R8: For a valid descriptor, the domain index n is taken from descriptor bits [8:5], and the domain code is read from `dacr[2n+1:2n]`. A code of 00 or 10 gives an abort with code 100 (section) or 101 (page).
- R9: For a valid descriptor whose domain code is 01 or 11, `proceed` pulses one cycle after `l1d_valid` and there is no abort.
- R10: While the checker waits for a descriptor, `req_ready` is 0 and `req_valid` is ignored.
- R11: `abort` and `proceed` are single-cycle result pulses and never high together. `fault_code` is 000 when there is no abort. `fault_addr` changes only in the cycle that `abort` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_ifetch | input | 1 | Request is an instruction fetch |
| req_page | input | 1 | Access is page-mapped (1) or section-mapped (0) |
| req_ready | output | 1 | Checker idle, request accepted |
| align_en | input | 1 | Alignment checking enable |
| mmu_en | input | 1 | Address translation enable |
| dacr | input | 32 | Sixteen 2-bit domain access codes |
| l1d_valid | input | 1 | Level-one descriptor strobe |
| l1d_data | input | 32 | Level-one descriptor |
| abort | output | 1 | Abort pulse |
| proceed | output | 1 | Access may go on to permission checking |
| fault_code | output | 3 | Fault type of the abort |
| fault_page | output | 1 | Aborted access was page-mapped |
| fault_addr | output | 32 | Address of the last aborted access |

## Verification
The result of one request and the acceptance of the next can happen in the same cycle: `req_ready` is high again in the cycle in which `abort` or `proceed` is shown. The bench issues back-to-back misaligned requests with different addresses. The scoreboard then has to see two aborts in a row, each carrying its own address. In a second case, a descriptor strobe arrives in the cycle that a misaligned request is being aborted. That strobe must cause no second result, and any extra pulse from it would be caught by the scoreboard as unexpected.

// File: rtl/afc_pkg.sv
package afc_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRD2 = 2'b11
  } acc_size_e;

  typedef enum logic [2:0] {
    FT_NONE     = 3'b000,
    FT_ALIGN    = 3'b001,
    FT_XLAT_SEC = 3'b010,
    FT_XLAT_PG  = 3'b011,
    FT_DOM_SEC  = 3'b100,
    FT_DOM_PG   = 3'b101
  } fault_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } chk_state_e;

endpackage

// File: rtl/afc_align.sv
module afc_align
  import afc_pkg::*;
(
  input  logic [1:0] addr_lo,
  input  logic [1:0] size,
  input  logic       ifetch,
  input  logic       en,
  output logic       misal
);

  acc_size_e sz;
  logic      word_bad;
  logic      half_bad;

  assign sz       = acc_size_e'(size);
  assign word_bad = (sz == SZ_WORD || sz == SZ_WRD2) && (addr_lo != 2'b00);
  assign half_bad = (sz == SZ_HALF) && addr_lo[0];
  assign misal    = en && !ifetch && (word_bad || half_bad);

endmodule

// File: rtl/afc_domain.sv
module afc_domain #(
  parameter int NUM_DOM = 16,
  parameter int CODE_W  = 2,
  localparam int IDX_W  = $clog2(NUM_DOM),
  localparam int DACR_W = NUM_DOM * CODE_W
) (
  input  logic [DACR_W-1:0] dacr,
  input  logic [1:0]        desc_type,
  input  logic [IDX_W-1:0]  desc_dom,
  output logic              desc_invalid,
  output logic              dom_deny
);

  logic [CODE_W-1:0] entry [NUM_DOM];
  logic [CODE_W-1:0] sel_code;

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_unpack
    assign entry[g] = dacr[g*CODE_W +: CODE_W];
  end

  assign sel_code     = entry[desc_dom];
  assign desc_invalid = (desc_type == 2'b00);
  // codes 00 (no access) and 10 (reserved) both deny: low bit clear
  assign dom_deny     = !sel_code[0];

endmodule

// File: rtl/afc_ctrl.sv
module afc_ctrl
  import afc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_page,
  input  logic              misal,
  input  logic              mmu_en,
  input  logic              l1d_valid,
  input  logic              desc_invalid,
  input  logic              dom_deny,
  output logic              req_ready,
  output logic              abort,
  output logic              proceed,
  output logic [2:0]        fault_code,
  output logic              fault_page,
  output logic [ADDR_W-1:0] fault_addr
);

  chk_state_e        state_q, state_d;
  logic [ADDR_W-1:0] pend_addr_q, pend_addr_d;
  logic              pend_page_q, pend_page_d;
  logic              pend_en;
  logic [ADDR_W-1:0] faddr_q, faddr_d;
  logic              faddr_en;
  logic              abort_q, abort_d;
  logic              proc_q, proc_d;
  fault_e            code_q, code_d;
  logic              fpage_q, fpage_d;

  always_comb begin
    state_d     = state_q;
    pend_addr_d = req_addr;
    pend_page_d = req_page;
    pend_en     = 1'b0;
    faddr_d     = req_addr;
    faddr_en    = 1'b0;
    abort_d     = 1'b0;
    proc_d      = 1'b0;
    code_d      = FT_NONE;
    fpage_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (misal) begin
            abort_d  = 1'b1;
            code_d   = FT_ALIGN;
            faddr_en = 1'b1;
          end else if (!mmu_en) begin
            proc_d = 1'b1;
          end else begin
            state_d = ST_WAIT;
            pend_en = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (l1d_valid) begin
          state_d = ST_IDLE;
          faddr_d = pend_addr_q;
          if (desc_invalid) begin
            abort_d  = 1'b1;
            code_d   = pend_page_q ? FT_XLAT_PG : FT_XLAT_SEC;
            fpage_d  = pend_page_q;
            faddr_en = 1'b1;
          end else if (dom_deny) begin
            abort_d  = 1'b1;
            code_d   = pend_page_q ? FT_DOM_PG : FT_DOM_SEC;
            fpage_d  = pend_page_q;
            faddr_en = 1'b1;
          end else begin
            proc_d = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      abort_q <= 1'b0;
      proc_q  <= 1'b0;
      code_q  <= FT_NONE;
      fpage_q <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= abort_d;
      proc_q  <= proc_d;
      code_q  <= code_d;
      fpage_q <= fpage_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_addr_q <= '0;
      pend_page_q <= 1'b0;
    end else if (pend_en) begin
      pend_addr_q <= pend_addr_d;
      pend_page_q <= pend_page_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      faddr_q <= '0;
    end else if (faddr_en) begin
      faddr_q <= faddr_d;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign abort      = abort_q;
  assign proceed    = proc_q;
  assign fault_code = code_q;
  assign fault_page = fpage_q;
  assign fault_addr = faddr_q;

endmodule

// File: rtl/acc_fault_check.sv
module acc_fault_check #(
  parameter int ADDR_W  = 32,
  parameter int DESC_W  = 32,
  parameter int NUM_DOM = 16,
  parameter int DOM_LSB = 5,
  localparam int IDX_W  = $clog2(NUM_DOM),
  localparam int DACR_W = 2 * NUM_DOM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_ifetch,
  input  logic              req_page,
  output logic              req_ready,
  input  logic              align_en,
  input  logic              mmu_en,
  input  logic [DACR_W-1:0] dacr,
  input  logic              l1d_valid,
  input  logic [DESC_W-1:0] l1d_data,
  output logic              abort,
  output logic              proceed,
  output logic [2:0]        fault_code,
  output logic              fault_page,
  output logic [ADDR_W-1:0] fault_addr
);

  logic misal;
  logic desc_invalid;
  logic dom_deny;
  logic unused_desc_bits;

  assign unused_desc_bits = ^{l1d_data[DESC_W-1:DOM_LSB+IDX_W], l1d_data[DOM_LSB-1:2]};

  afc_align u_align (
    .addr_lo (req_addr[1:0]),
    .size    (req_size),
    .ifetch  (req_ifetch),
    .en      (align_en),
    .misal   (misal)
  );

  afc_domain #(.NUM_DOM(NUM_DOM), .CODE_W(2)) u_domain (
    .dacr         (dacr),
    .desc_type    (l1d_data[1:0]),
    .desc_dom     (l1d_data[DOM_LSB +: IDX_W]),
    .desc_invalid (desc_invalid),
    .dom_deny     (dom_deny)
  );

  afc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_page     (req_page),
    .misal        (misal),
    .mmu_en       (mmu_en),
    .l1d_valid    (l1d_valid),
    .desc_invalid (desc_invalid),
    .dom_deny     (dom_deny),
    .req_ready    (req_ready),
    .abort        (abort),
    .proceed      (proceed),
    .fault_code   (fault_code),
    .fault_page   (fault_page),
    .fault_addr   (fault_addr)
  );

endmodule

// File: rtl/afc_checker.sv
module afc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              req_ifetch,
  input logic              align_en,
  input logic              mmu_en,
  input logic              l1d_valid,
  input logic [1:0]        l1d_type,
  input logic              abort,
  input logic              proceed,
  input logic [2:0]        fault_code,
  input logic [ADDR_W-1:0] fault_addr
);

  logic accept;
  assign accept = req_valid && req_ready;

  // R2: misaligned word data access aborts with code 001 and its address
  a_r2_word_align: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && align_en && !req_ifetch && req_size[1] && req_addr[1:0] != 2'b00)
    |=> (abort && fault_code == 3'b001 && fault_addr == $past(req_addr)));

  // R4: fetches and byte accesses never give an alignment fault
  a_r4_no_align_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_ifetch || req_size == 2'b00)) |=> (fault_code != 3'b001));

  // R6: translation off and no alignment hazard gives an immediate pass
  a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mmu_en && (req_ifetch || req_size == 2'b00)) |=> (proceed && !abort));

  // R7: invalid descriptor while waiting gives a translation fault
  a_r7_xlat: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && l1d_valid && l1d_type == 2'b00) |=> (abort && fault_code[2:1] == 2'b01));

  // R10: no result is shown while waiting on a descriptor
  a_r10_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (!abort && !proceed));

  // R11: abort and proceed never together
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort && proceed));

  // R11: fault address moves only with an abort
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !abort |-> $stable(fault_addr));

  // R11: code is 000 whenever no abort is shown
  a_r11_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !abort |-> (fault_code == 3'b000));

endmodule

bind acc_fault_check afc_checker #(.ADDR_W(ADDR_W)) u_afc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_size   (req_size),
  .req_ifetch (req_ifetch),
  .align_en   (align_en),
  .mmu_en     (mmu_en),
  .l1d_valid  (l1d_valid),
  .l1d_type   (l1d_data[1:0]),
  .abort      (abort),
  .proceed    (proceed),
  .fault_code (fault_code),
  .fault_addr (fault_addr)
);

// File: tb/tb_acc_fault_check.sv
`timescale 1ns/1ps
module tb_acc_fault_check;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic        req_ifetch;
  logic        req_page;
  logic        req_ready;
  logic        align_en;
  logic        mmu_en;
  logic [31:0] dacr;
  logic        l1d_valid;
  logic [31:0] l1d_data;
  logic        abort;
  logic        proceed;
  logic [2:0]  fault_code;
  logic        fault_page;
  logic [31:0] fault_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    bit          ab;
    bit          pr;
    logic [2:0]  code;
    bit          pg;
    logic [31:0] addr;
    string       rq;
  } exp_t;

  exp_t sb[$];
  exp_t e;

  acc_fault_check dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_ifetch(req_ifetch), .req_page(req_page),
    .req_ready(req_ready), .align_en(align_en), .mmu_en(mmu_en), .dacr(dacr),
    .l1d_valid(l1d_valid), .l1d_data(l1d_data), .abort(abort), .proceed(proceed),
    .fault_code(fault_code), .fault_page(fault_page), .fault_addr(fault_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp_v);
    end
  endtask

  function automatic bit model_misal(logic [31:0] a, logic [1:0] sz, bit fetch, bit en);
    if (!en || fetch) return 0;
    if (sz[1]) return a[1:0] != 2'b00;
    if (sz == 2'b01) return a[0];
    return 0;
  endfunction

  function automatic logic [1:0] model_dom(logic [31:0] d, logic [31:0] desc);
    int n;
    n = int'(desc[8:5]);
    return d[2*n +: 2];
  endfunction

  task automatic push(input bit ab, input bit pr, input logic [2:0] code,
                      input bit pg, input logic [31:0] a, input string rq);
    exp_t x;
    x.ab = ab; x.pr = pr; x.code = code; x.pg = pg; x.addr = a; x.rq = rq;
    sb.push_back(x);
  endtask

  // called at a negedge, returns at the negedge after acceptance
  task automatic issue(input logic [31:0] a, input logic [1:0] sz, input bit fetch,
                       input bit pg, input string rq);
    req_addr = a; req_size = sz; req_ifetch = fetch; req_page = pg; req_valid = 1'b1;
    if (model_misal(a, sz, fetch, align_en))
      push(1, 0, 3'b001, 0, a, rq);
    else if (!mmu_en)
      push(0, 1, 3'b000, 0, a, rq);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic give_desc(input logic [31:0] desc, input bit pg,
                           input logic [31:0] a, input string rq);
    logic [1:0] dc;
    l1d_data = desc; l1d_valid = 1'b1;
    dc = model_dom(dacr, desc);
    if (desc[1:0] == 2'b00)      push(1, 0, pg ? 3'b011 : 3'b010, pg, a, rq);
    else if (dc[0] == 1'b0)      push(1, 0, pg ? 3'b101 : 3'b100, pg, a, rq);
    else                         push(0, 1, 3'b000, 0, a, rq);
    @(posedge clk);
    @(negedge clk);
    l1d_valid = 1'b0;
  endtask

  function automatic logic [31:0] mk_desc(int dom, logic [1:0] typ);
    return (32'(dom) << 5) | {30'h0, typ};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (abort || proceed)) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected result abort=%b proceed=%b code=%b expected none",
                 abort, proceed, fault_code);
      end else begin
        e = sb.pop_front();
        if (abort !== e.ab || proceed !== e.pr || fault_code !== e.code ||
            (e.ab && (fault_page !== e.pg || fault_addr !== e.addr))) begin
          fails++;
          $display("FAIL %s actual ab=%b pr=%b code=%b pg=%b addr=%h expected ab=%b pr=%b code=%b pg=%b addr=%h",
                   e.rq, abort, proceed, fault_code, fault_page, fault_addr,
                   e.ab, e.pr, e.code, e.pg, e.addr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_addr = 0; req_size = 0; req_ifetch = 0;
    req_page = 0; align_en = 0; mmu_en = 0; l1d_valid = 0; l1d_data = 0;
    dacr = 32'h5555_5555;
    dacr[2*3 +: 2] = 2'b00;
    dacr[2*7 +: 2] = 2'b10;
    dacr[2*15 +: 2] = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ready",   32'(req_ready),  32'd1);
    check("R1 abort",   32'(abort),      32'd0);
    check("R1 proceed", 32'(proceed),    32'd0);
    check("R1 code",    32'(fault_code), 32'd0);

    // R2 misaligned words
    align_en = 1;
    issue(32'h1000_0001, 2'b10, 0, 0, "R2 word addr+1");
    issue(32'h1000_0102, 2'b11, 0, 0, "R2 word addr+2");
    // R3 halfword
    issue(32'h2000_0003, 2'b01, 0, 0, "R3 half odd");
    issue(32'h2000_0002, 2'b01, 0, 0, "R3 half addr+2 ok");
    // R4 exemptions, R6 bypass
    issue(32'h3000_0003, 2'b00, 0, 0, "R4 byte R6");
    issue(32'h3000_0003, 2'b10, 1, 0, "R4 fetch R6");
    align_en = 0;
    issue(32'h3000_0001, 2'b10, 0, 0, "R4 check off R6");
    align_en = 1;
    @(negedge clk);

    // R5 alignment with translation on, descriptor strobe ignored
    mmu_en = 1;
    issue(32'h4000_0002, 2'b10, 0, 1, "R5 align mmu on");
    check("R5 ready after align fault", 32'(req_ready), 32'd1);
    l1d_data = 32'h0; l1d_valid = 1;
    @(negedge clk);
    l1d_valid = 0;
    check("R5 ready after stray strobe", 32'(req_ready), 32'd1);
    @(negedge clk);

    // R7 translation faults
    issue(32'h5000_0000, 2'b10, 0, 0, "R7");
    check("R10 ready low while waiting", 32'(req_ready), 32'd0);
    give_desc(mk_desc(9, 2'b00), 0, 32'h5000_0000, "R7 section");
    issue(32'h5000_0010, 2'b00, 0, 1, "R7");
    give_desc(mk_desc(9, 2'b00), 1, 32'h5000_0010, "R7 page");

    // R8 domain faults
    issue(32'h6000_0020, 2'b10, 0, 0, "R8");
    give_desc(mk_desc(3, 2'b10), 0, 32'h6000_0020, "R8 dom3 no access");
    issue(32'h6000_0040, 2'b01, 0, 1, "R8");
    give_desc(mk_desc(7, 2'b01), 1, 32'h6000_0040, "R8 dom7 reserved");

    // R9 passing domains, R11 address held after proceed
    issue(32'h7000_0000, 2'b10, 0, 0, "R9");
    give_desc(mk_desc(9, 2'b10), 0, 32'h7000_0000, "R9 dom9 client");
    issue(32'h7000_0004, 2'b10, 1, 1, "R9");
    give_desc(mk_desc(15, 2'b01), 1, 32'h7000_0004, "R9 dom15 manager");
    check("R11 fault_addr held", fault_addr, 32'h6000_0040);

    // R10 request while busy is ignored
    issue(32'h8000_0000, 2'b10, 0, 0, "R10");
    req_addr = 32'h8000_0001; req_size = 2'b10; req_ifetch = 0; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check("R10 still waiting", 32'(req_ready), 32'd0);
    give_desc(mk_desc(15, 2'b10), 0, 32'h8000_0000, "R10 pending pass");
    check("R10 busy request left no fault", fault_addr, 32'h6000_0040);

    // R11 back-to-back aborts, descriptor strobe alongside
    issue(32'h9000_0001, 2'b10, 0, 0, "R11 first");
    l1d_valid = 1; l1d_data = 32'h0;
    issue(32'h9000_0011, 2'b01, 0, 0, "R11 second");
    l1d_valid = 0;
    repeat (3) @(negedge clk);
    check("R11 scoreboard drained", 32'(sb.size()), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule